// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the slave end of a three-wire serial bus that gives a host access to a bank of 16-bit configuration registers. The three wires are a serial clock, an active-low enable and one shared data line. The block has no system clock of its own. Every flop runs from the serial clock, and the contents of the registers go straight out to the rest of the chip as one flat vector.

A transaction starts when the enable is low and the block samples the data line on each rising clock edge. The fields arrive in this order: a start bit, a direction flag and a 7-bit register address. For a write, the host then sends 16 data bits. For a read, the host lets go of the line. The block waits through a turnaround of one and a half bit periods, then drives the 16-bit word back, changing the line on falling edges. The frame decoder returns to its idle state only on a rising clock edge seen while the enable is high. So the host must give one such edge between frames.

The data line is presented as separate input, output and output-enable signals, so that the pad at chip level can form the bidirectional pin.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is low on a rising edge, register i takes the value RST_BASE + 257*i (kept to 16 bits), and the output enable of the data line is low.
- R2: With the enable low, bits are sampled on rising edges in this order: start bit (0 = valid), direction flag (1 = read, 0 = write), then the 7-bit address, most significant bit first.
- R3: A write frame sends 16 data bits after the address, most significant bit first. The word is stored in the addressed register on the rising edge that samples the last data bit, and it then appears on cfg_flat[16*i +: 16].
- R4: A write frame whose enable rises before all 16 data bits have been sampled leaves every register unchanged.
- R5: In a read frame the output enable stays low through the falling edge that follows the last address bit. It also stays low through the next rising edge. From the falling edge after that (1.5 bit periods after the last address bit was sampled), the block drives 16 bits, most significant bit first, with one new bit on each falling edge.
- R6: A read returns the addressed register. An address at or above NUM_REGS reads as all zeros.
- R7: A write to an address at or above NUM_REGS changes no register.
- R8: The output enable is low whenever the enable input is high. It is also low from the falling edge that follows the sampling of the 16th read bit.
- R9: A new frame is decoded only after a rising edge with the enable high. Bits that arrive while the enable stays low after a complete frame are ignored.
- R10: A frame whose start bit is 1 is ignored: no register changes and the data line is never driven.
- R11: A read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bus clock; the only clock of the block |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low transaction enable |
| sdio_i | input | 1 | Data line value as seen at the pad |
| sdio_o | output | 1 | Data line value driven during a read |
| sdio_oe | output | 1 | High while the block drives the data line |
| cfg_flat | output | NUM_REGS*16 | All register contents, register i at bits 16*i+15 down to 16*i |

## Verification
The bench builds the block with NUM_REGS = 12 and RST_BASE = 16'hA0C3. With twelve registers, the address range 12 to 127 is in reach, so most random addresses are unimplemented, and both the zero read-back and the ignored write are exercised often. The reset pattern puts a distinct, non-zero value in every register, so a write that lands at the wrong address, or a read that picks the wrong register, shows up as a mismatch. The random mix also truncates write frames at every length from 1 to 24 bits.

// File: rtl/scp_pkg.sv
// Package scp_pkg
// Shared frame geometry, data types and the reset-value rule of the serial
// configuration port. Assumes the frame layout start/dir/address/data is fixed.
package scp_pkg;

    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int HDR_BITS   = 2 + ADDR_W;          // start + direction + address
    localparam int FRAME_BITS = HDR_BITS + DATA_W;   // full write frame
    localparam int CNT_MAX    = FRAME_BITS + 1;      // saturation value of the bit counter
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int IDX_W      = $clog2(DATA_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Reset value of register idx: base plus idx copies of 0x0101.
    function automatic word_t reset_word(input word_t base, input int idx);
        return word_t'(int'(base) + idx * 257);
    endfunction

endpackage

// File: rtl/scp_frame_rx.sv
// Module scp_frame_rx
// Counts sampled bits of a frame, captures the start bit, direction and
// address, and raises the write and read-load strobes at the right bit.
// Assumes all inputs are stable around the rising edge of clk and that a
// rising edge with en_n high separates frames.
module scp_frame_rx
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_n,
    input  logic  sdi,
    output cnt_t  cnt,
    output logic  start_ok,
    output logic  is_read,
    output logic  wr_en,
    output addr_t wr_addr,
    output word_t wr_data,
    output logic  rd_load,
    output addr_t rd_addr
);

    localparam cnt_t C_START = cnt_t'(0);
    localparam cnt_t C_DIR   = cnt_t'(1);
    localparam cnt_t C_ALAST = cnt_t'(HDR_BITS - 1);
    localparam cnt_t C_DLAST = cnt_t'(FRAME_BITS - 1);
    localparam cnt_t C_SAT   = cnt_t'(CNT_MAX);

    cnt_t                cnt_q;
    logic                start_q;
    logic                read_q;
    logic [DATA_W-2:0]   sh_q;
    addr_t               addr_q;

    // Bit counter and header capture; idle whenever enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
            read_q  <= 1'b0;
            sh_q    <= '0;
            addr_q  <= '0;
        end else if (en_n) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
            read_q  <= 1'b0;
        end else begin
            if (cnt_q != C_SAT) cnt_q <= cnt_q + cnt_t'(1);
            if (cnt_q == C_START) start_q <= ~sdi;
            if (cnt_q == C_DIR)   read_q  <= sdi;
            sh_q <= {sh_q[DATA_W-3:0], sdi};
            if (cnt_q == C_ALAST) addr_q <= {sh_q[ADDR_W-2:0], sdi};
        end
    end

    // Strobes decoded from the current bit position.
    always_comb begin
        wr_en   = ~en_n & start_q & ~read_q & (cnt_q == C_DLAST);
        wr_data = {sh_q, sdi};
        rd_load = ~en_n & start_q & read_q & (cnt_q == C_ALAST);
        rd_addr = {sh_q[ADDR_W-2:0], sdi};
    end

    assign cnt      = cnt_q;
    assign start_ok = start_q;
    assign is_read  = read_q;
    assign wr_addr  = addr_q;

    // R3: at most one commit per frame.
    a_r3_one_commit_per_frame: assert property (
        @(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en);

    // R9: a saturated counter only leaves saturation through the idle state.
    a_r9_idle_needed_after_frame: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cnt_q == C_SAT) |=> (cnt_q == C_SAT || cnt_q == '0));

endmodule

// File: rtl/scp_cfg_bank.sv
// Module scp_cfg_bank
// Holds NUM_REGS configuration words, writes one on a strobe and returns
// the word for a read address, zero outside the implemented range.
// Assumes NUM_REGS does not exceed the 7-bit address space.
module scp_cfg_bank
    import scp_pkg::*;
#(
    parameter int    NUM_REGS = 8,
    parameter word_t RST_BASE = 16'h1200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  addr_t                      wr_addr,
    input  word_t                      wr_data,
    input  addr_t                      rd_addr,
    output word_t                      rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

    word_t regs [NUM_REGS];
    logic  live_q;

    initial begin
        if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W))
            $error("NUM_REGS out of range");
    end

    generate
        for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            localparam word_t RV = reset_word(RST_BASE, gi);
            // One register: reset pattern, then loaded by a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= RV;
                else if (wr_en && (wr_addr == addr_t'(gi)))
                    regs[gi] <= wr_data;
            end
            assign cfg_flat[gi*DATA_W +: DATA_W] = regs[gi];
        end
    endgenerate

    // Read select; unmatched addresses give zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == addr_t'(i)) rd_data = regs[i];
    end

    // Marks the cycles after the first post-reset edge for the checker.
    always_ff @(posedge clk) live_q <= rst_n;

    // R3/R4/R7/R11: register contents move only after a write strobe.
    a_r3_change_only_on_commit: assert property (
        @(posedge clk) disable iff (!rst_n || !live_q)
        !$stable(cfg_flat) |-> $past(wr_en));

endmodule

// File: rtl/scp_read_drv.sv
// Module scp_read_drv
// Holds the word picked at the end of a read header and shifts it onto
// the data line from falling edges after the 1.5-bit turnaround.
// Assumes the bit counter changes only on rising edges.
module scp_read_drv
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_load,
    input  word_t rd_word,
    input  cnt_t  cnt,
    input  logic  start_ok,
    input  logic  is_read,
    output logic  drive,
    output logic  bit_out
);

    localparam cnt_t C_FIRST = cnt_t'(HDR_BITS + 1);
    localparam cnt_t C_LAST  = cnt_t'(FRAME_BITS);
    localparam cnt_t C_TA    = cnt_t'(HDR_BITS);
    localparam cnt_t C_SAT   = cnt_t'(CNT_MAX);

    word_t              shadow_q;
    logic               rd_phase;
    logic [IDX_W-1:0]   idx;
    logic               drive_q;
    logic               bit_q;

    // Capture the addressed word as the last address bit is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (rd_load) shadow_q <= rd_word;
    end

    // Data phase window and bit select, most significant bit first.
    always_comb begin
        rd_phase = start_ok & is_read & (cnt >= C_FIRST) & (cnt <= C_LAST);
        idx      = IDX_W'(FRAME_BITS - int'(cnt));
    end

    // Line driver updated on falling edges.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            drive_q <= rd_phase;
            if (rd_phase) bit_q <= shadow_q[idx];
        end
    end

    assign drive   = drive_q;
    assign bit_out = bit_q;

    // R5: nothing is driven during the header or the turnaround.
    a_r5_quiet_in_turnaround: assert property (
        @(posedge clk) disable iff (!rst_n) (cnt <= C_TA) |-> !drive_q);

    // R8: the line is released once the word is complete.
    a_r8_release_after_word: assert property (
        @(posedge clk) disable iff (!rst_n) (cnt == C_SAT) |-> !drive_q);

    // R10: a frame with a bad start bit never drives the line.
    a_r10_bad_start_silent: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!start_ok && cnt >= cnt_t'(2)) |-> !drive_q);

endmodule

// File: rtl/serial_cfg_port.sv
// Module serial_cfg_port
// Top of the three-wire serial configuration port: frame decoder, register
// bank and read driver, with split pad signals for the shared data line.
// Assumes clk is the serial bus clock and the pad merges sdio_o/sdio_oe.
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int    NUM_REGS = 8,
    parameter word_t RST_BASE = 16'h1200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_n,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

    cnt_t  cnt;
    logic  start_ok, is_read, wr_en, rd_load, drive, bit_out;
    addr_t wr_addr, rd_addr;
    word_t wr_data, rd_data;

    scp_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sdi(sdio_i),
        .cnt(cnt), .start_ok(start_ok), .is_read(is_read),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_load(rd_load), .rd_addr(rd_addr)
    );

    scp_cfg_bank #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_flat(cfg_flat)
    );

    scp_read_drv u_drv (
        .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_word(rd_data),
        .cnt(cnt), .start_ok(start_ok), .is_read(is_read),
        .drive(drive), .bit_out(bit_out)
    );

    // Pad controls: never drive while the enable is high.
    assign sdio_oe = drive & ~en_n;
    assign sdio_o  = bit_out & sdio_oe;

endmodule

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;

    localparam int          N    = 12;
    localparam logic [15:0] BASE = 16'hA0C3;

    logic clk = 1'b0;
    logic rst_n, en_n, sdi;
    logic sdio_o, sdio_oe;
    logic [N*16-1:0] cfg_flat;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [15:0] model [N];

    always #2.5 clk = ~clk;

    serial_cfg_port #(.NUM_REGS(N), .RST_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sdio_i(sdi),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .cfg_flat(cfg_flat)
    );

    function automatic logic [15:0] exp_reset(input int i);
        return 16'(int'(BASE) + i * 257);
    endfunction

    function automatic logic [15:0] exp_read(input logic [6:0] a);
        return (int'(a) < N) ? model[a] : 16'h0000;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) check(req, cfg_flat[i*16 +: 16], model[i]);
    endtask

    task automatic write_frame(input logic [6:0] a, input logic [15:0] d, input int nbits,
                               input logic st, input bit lead, input bit close);
        logic [24:0] fr;
        fr = {st, 1'b0, a, d};
        if (lead) begin @(negedge clk); en_n = 1'b1; end
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); en_n = 1'b0; sdi = fr[24-i];
        end
        if (close) begin @(negedge clk); en_n = 1'b1; sdi = 1'b0; end
    endtask

    task automatic send_hdr(input logic st, input logic rw, input logic [6:0] a);
        logic [8:0] h;
        h = {st, rw, a};
        @(negedge clk); en_n = 1'b1;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); en_n = 1'b0; sdi = h[8-i];
        end
    endtask

    task automatic read_frame(input logic [6:0] a, input logic st, output logic [15:0] got,
                              output logic ta_quiet, output int drv_cnt, output logic tail_quiet);
        send_hdr(st, 1'b1, a);
        @(negedge clk); sdi = 1'b0; #1 ta_quiet = !sdio_oe;
        got = '0; drv_cnt = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); #1;
            got[15-k] = sdio_o;
            if (sdio_oe) drv_cnt++;
        end
        @(negedge clk); #1 tail_quiet = !sdio_oe;
        en_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(150000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic ta, tail;
        int dc;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; en_n = 1'b1; sdi = 1'b0;
        for (int i = 0; i < N; i++) model[i] = exp_reset(i);
        repeat (4) @(negedge clk);
        #1 check("R1 oe in reset", 16'(sdio_oe), 16'h0);
        @(negedge clk); rst_n = 1'b1;
        #1 check_all("R1 reset values");

        // R2/R3: basic write, MSB first
        write_frame(7'd3, 16'h8001, 25, 1'b0, 1, 1);
        model[3] = 16'h8001;
        check_all("R3 write addr 3");

        // R5/R6/R8: read back with turnaround and release
        read_frame(7'd3, 1'b0, got, ta, dc, tail);
        check("R6 read addr 3", got, 16'h8001);
        check("R5 turnaround quiet", 16'(ta), 16'h1);
        check("R5 sixteen driven bits", 16'(dc), 16'd16);
        check("R8 release after word", 16'(tail), 16'h1);
        #1 check("R8 oe low with enable high", 16'(sdio_oe), 16'h0);

        // R4: truncated writes
        write_frame(7'd5, 16'h1234, 24, 1'b0, 1, 1);
        write_frame(7'd5, 16'h1234, 10, 1'b0, 1, 1);
        check_all("R4 short write discarded");

        // R7/R6: unimplemented addresses
        write_frame(7'd127, 16'hFFFF, 25, 1'b0, 1, 1);
        write_frame(7'd12, 16'h5A5A, 25, 1'b0, 1, 1);
        check_all("R7 unimplemented write ignored");
        read_frame(7'd127, 1'b0, got, ta, dc, tail);
        check("R6 unimplemented 127 reads zero", got, 16'h0000);
        read_frame(7'd12, 1'b0, got, ta, dc, tail);
        check("R6 unimplemented 12 reads zero", got, 16'h0000);
        read_frame(7'd11, 1'b0, got, ta, dc, tail);
        check("R6 last register", got, model[11]);

        // R10: bad start bit
        write_frame(7'd2, 16'hDEAD, 25, 1'b1, 1, 1);
        check_all("R10 bad start write ignored");
        read_frame(7'd2, 1'b1, got, ta, dc, tail);
        check("R10 bad start no drive", 16'(dc), 16'd0);

        // R9: no idle edge between frames
        write_frame(7'd1, 16'h0F0F, 25, 1'b0, 1, 0);
        write_frame(7'd1, 16'hF0F0, 25, 1'b0, 0, 1);
        model[1] = 16'h0F0F;
        check_all("R9 second frame without idle edge ignored");
        write_frame(7'd1, 16'hF0F0, 25, 1'b0, 1, 1);
        model[1] = 16'hF0F0;
        check_all("R9 frame after idle edge accepted");

        // R8: enable raised in the middle of a read
        send_hdr(1'b0, 1'b1, 7'd3);
        repeat (4) @(negedge clk);
        #1 check("R8 driving mid read", 16'(sdio_oe), 16'h1);
        en_n = 1'b1;
        #1 check("R8 oe drops with enable", 16'(sdio_oe), 16'h0);
        @(negedge clk); #1 check("R8 oe stays low", 16'(sdio_oe), 16'h0);

        // Random mix against the model
        for (int n = 0; n < 300; n++) begin
            int op;
            logic [6:0] a;
            logic [15:0] d;
            op = int'($urandom % 4);
            a  = 7'($urandom % 128);
            d  = 16'($urandom);
            case (op)
                0: begin
                    write_frame(a, d, 25, 1'b0, 1, 1);
                    if (int'(a) < N) model[a] = d;
                    if (int'(a) < N) check("R3 random write", cfg_flat[int'(a)*16 +: 16], d);
                end
                1: begin
                    read_frame(a, 1'b0, got, ta, dc, tail);
                    check("R6 random read", got, exp_read(a));
                end
                2: begin
                    write_frame(7'($urandom % N), d, 1 + int'($urandom % 24), 1'b0, 1, 1);
                end
                default: begin
                    a = 7'($urandom % N);
                    write_frame(a, d, 25, 1'b0, 1, 1);
                    model[a] = d;
                    read_frame(a, 1'b0, got, ta, dc, tail);
                    check("R6 write then read", got, d);
                end
            endcase
        end
        check_all("R11 final contents match model");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule